// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block steers the level-sensitive interrupts of up to `NUM_DEV` PCI devices onto the 16 inputs of a legacy interrupt controller. A device reports a change on one of its four interrupt pins (A to D) as a single-cycle event. The event carries the device's tracking index, its slot number, the pin and the new level. The router rotates the pin by the slot to choose one of four shared interrupt lines. It keeps one level bit per device per line, so a line stays active while any device that maps onto it holds its pin high.

Each shared line has an 8-bit steering register. The register either names one controller input (values 0 to 15) or leaves the line unconnected (16 or more). Several lines may name the same input. That input is then driven with the OR of all of them. The 16-bit result is registered before it leaves the block. The steering registers are loaded through a plain write port: a strobe, a 2-bit line select and an 8-bit value.

Top module: `pirq_router`

## Requirements
- R1: After a synchronous active-low reset, the output vector is 0x0000, every device level bit is cleared, and all four steering registers hold 0x80, so no line reaches the controller until it is programmed.
- R2: A device event selects line (pin + slot - 1) mod 4. The pin is encoded 0=A, 1=B, 2=C, 3=D, and the slot is the 5-bit device number.
- R3: A line is active while at least one device whose events map onto it holds level 1. When one device drops its level, the line stays active if another device still holds it.
- R4: A write with `cfg_wr_en` high stores `cfg_wr_data` into the steering register of line `cfg_wr_sel` (0 to 3). A value of 0 to 15 connects that line to the controller input with that number.
- R5: A steering value of 16 or more leaves the line unconnected, and no output bit follows that line.
- R6: An output bit is the OR of every connected line whose steering register names it.
- R7: When a steering register is rewritten, the old target input drops and the new target input rises in the same output cycle.
- R8: A device event or a steering write sampled at clock edge N is first visible on `ctrl_irq_o` after edge N+1.
- R9: A device event with level 0 clears only that device's bit on the selected line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Device interrupt event strobe |
| ev_dev | input | DEV_W | Tracking index of the reporting device |
| ev_slot | input | SLOT_W | Slot number of the reporting device |
| ev_pin | input | 2 | Interrupt pin, 0=A to 3=D |
| ev_level | input | 1 | New level of that pin |
| cfg_wr_en | input | 1 | Steering register write strobe |
| cfg_wr_sel | input | 2 | Line whose steering register is written |
| cfg_wr_data | input | 8 | Steering value |
| ctrl_irq_o | output | NUM_INPUTS | Registered level per controller input |

## Verification
Every result is due two clock edges after its stimulus. This holds for both device events and steering writes: the first edge updates the level bits or the steering register, and the second edge loads the output register. The bench drives inputs on falling edges and drops the strobe after one edge. It compares `ctrl_irq_o` on the falling edge that follows the second rising edge. For the latency and rewrite cases it also samples after the first edge, and expects the previous value there.

// File: rtl/pirq_pkg.sv
// Package: shared types and the slot rotation for the interrupt router.
// Assumes four shared lines (a power of two) and 8-bit steering values.
package pirq_pkg;
    localparam int LINES   = 4;
    localparam int LINE_W  = $clog2(LINES);
    localparam int ROUTE_W = 8;

    typedef logic [LINE_W-1:0]  line_t;
    typedef logic [ROUTE_W-1:0] route_t;

    localparam route_t ROUTE_OFF = 8'h80;

    // Rotate a pin by the low slot bits: (pin + slot - 1) mod LINES.
    function automatic line_t swizzle(input line_t pin, input line_t slot_lsb);
        line_t ones;
        ones = '1;
        return pin + slot_lsb + ones;
    endfunction
endpackage

// File: rtl/pirq_level_track.sv
// Module: holds one level bit per device per shared line, and reduces each
// line to its level. Assumes NUM_DEV is a power of two, with at most one
// event per cycle.
module pirq_level_track
    import pirq_pkg::*;
#(
    parameter int NUM_DEV = 16,
    localparam int DEV_W  = $clog2(NUM_DEV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_valid,
    input  logic [DEV_W-1:0] ev_dev,
    input  line_t            ev_line,
    input  logic             ev_level,
    output logic [LINES-1:0] line_lvl_o
);
    logic [LINES-1:0][NUM_DEV-1:0] lvl_q;

    // Update the one bit addressed by an event; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= '0;
        end else if (ev_valid) begin
            lvl_q[ev_line][ev_dev] <= ev_level;
        end
    end

    // Reduce the device bits of each line into one line level.
    generate
        for (genvar j = 0; j < LINES; j++) begin : g_line
            assign line_lvl_o[j] = |lvl_q[j];
        end
    endgenerate

    AST_LINE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_level) |=> line_lvl_o[$past(ev_line)]); // R3
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (line_lvl_o == '0)); // R1
endmodule

// File: rtl/pirq_route_regs.sv
// Module: four steering registers, one per shared line, loaded by a plain
// write port. Assumes that at most one write arrives per cycle.
module pirq_route_regs
    import pirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_en,
    input  line_t  wr_sel,
    input  route_t wr_data,
    output route_t route_o [LINES]
);
    route_t route_q [LINES];

    // Hold each steering register; a reset returns every line to unconnected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < LINES; j++) route_q[j] <= ROUTE_OFF;
        end else if (wr_en) begin
            route_q[wr_sel] <= wr_data;
        end
    end

    // Drive the stored values out to the steering logic.
    always_comb begin
        for (int j = 0; j < LINES; j++) route_o[j] = route_q[j];
    end

    AST_ROUTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (route_o[$past(wr_sel)] == $past(wr_data))); // R4
endmodule

// File: rtl/pirq_steer.sv
// Module: steers each connected line to its controller input, ORs the lines
// that share an input, and registers the vector. Assumes a value of
// NUM_INPUTS or more means unconnected.
module pirq_steer
    import pirq_pkg::*;
#(
    parameter int NUM_INPUTS = 16,
    localparam int IN_W      = $clog2(NUM_INPUTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [LINES-1:0]      line_lvl,
    input  route_t                route [LINES],
    output logic [NUM_INPUTS-1:0] irq_o
);
    logic [LINES-1:0]      conn;
    logic [NUM_INPUTS-1:0] hit;
    logic [NUM_INPUTS-1:0] named;
    logic [NUM_INPUTS-1:0] irq_q;

    // Mark each line whose steering value names a real input.
    generate
        for (genvar j = 0; j < LINES; j++) begin : g_conn
            assign conn[j] = (route[j] < ROUTE_W'(NUM_INPUTS));
        end
    endgenerate

    // For every input, OR together the active lines steered onto it.
    generate
        for (genvar k = 0; k < NUM_INPUTS; k++) begin : g_in
            always_comb begin
                hit[k]   = 1'b0;
                named[k] = 1'b0;
                for (int j = 0; j < LINES; j++) begin
                    if (conn[j] && (route[j][IN_W-1:0] == IN_W'(k))) begin
                        named[k] = 1'b1;
                        hit[k]   = hit[k] | line_lvl[j];
                    end
                end
            end

            AST_UNROUTED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
                !named[k] |=> !irq_o[k]); // R5
        end
    endgenerate

    // Register the steered vector for one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= hit;
    end

    assign irq_o = irq_q;

    AST_MAX_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(irq_o) <= LINES); // R6
endmodule

// File: rtl/pirq_router.sv
// Module: top of the PCI interrupt pin router. It rotates each device event
// onto a shared line, tracks device levels, and steers the lines onto the
// controller inputs. Assumes a synchronous active-low reset and single-cycle
// event and write strobes.
module pirq_router
    import pirq_pkg::*;
#(
    parameter int NUM_DEV    = 16,
    parameter int SLOT_W     = 5,
    parameter int NUM_INPUTS = 16,
    localparam int DEV_W     = $clog2(NUM_DEV)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ev_valid,
    input  logic [DEV_W-1:0]      ev_dev,
    input  logic [SLOT_W-1:0]     ev_slot,
    input  logic [1:0]            ev_pin,
    input  logic                  ev_level,
    input  logic                  cfg_wr_en,
    input  logic [1:0]            cfg_wr_sel,
    input  logic [7:0]            cfg_wr_data,
    output logic [NUM_INPUTS-1:0] ctrl_irq_o
);
    line_t            ev_line;
    logic [LINES-1:0] line_lvl;
    route_t           route [LINES];
    logic             unused_slot_hi;

    // The rotation only uses the low slot bits; the upper bits are unused.
    assign unused_slot_hi = ^ev_slot[SLOT_W-1:LINE_W];
    assign ev_line        = swizzle(ev_pin, ev_slot[LINE_W-1:0]);

    pirq_level_track #(.NUM_DEV(NUM_DEV)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_valid   (ev_valid),
        .ev_dev     (ev_dev),
        .ev_line    (ev_line),
        .ev_level   (ev_level),
        .line_lvl_o (line_lvl)
    );

    pirq_route_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_sel  (cfg_wr_sel),
        .wr_data (cfg_wr_data),
        .route_o (route)
    );

    pirq_steer #(.NUM_INPUTS(NUM_INPUTS)) u_steer (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_lvl (line_lvl),
        .route    (route),
        .irq_o    (ctrl_irq_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl_irq_o == '0)); // R1
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ev_valid && !cfg_wr_en && !$past(ev_valid) && !$past(cfg_wr_en))
        |=> $stable(ctrl_irq_o)); // R8
endmodule

// File: tb/pirq_router_tb.sv
module pirq_router_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [3:0]  ev_dev = '0;
    logic [4:0]  ev_slot = '0;
    logic [1:0]  ev_pin = '0;
    logic        ev_level = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_sel = '0;
    logic [7:0]  cfg_wr_data = '0;
    logic [15:0] ctrl_irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    pirq_router dut_i (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_dev(ev_dev),
        .ev_slot(ev_slot), .ev_pin(ev_pin), .ev_level(ev_level),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .ctrl_irq_o(ctrl_irq_o)
    );

    // Table: {dev[4], slot[5], pin[2], level[1], expected output[16]}.
    // Steering while the table runs: line0->3, line1->4, line2->5, line3->6.
    localparam int NVEC = 12;
    localparam logic [27:0] VEC [NVEC] = '{
        {4'd0, 5'd1,  2'd0, 1'b1, 16'h0008},
        {4'd1, 5'd2,  2'd0, 1'b1, 16'h0018},
        {4'd2, 5'd0,  2'd0, 1'b1, 16'h0058},
        {4'd3, 5'd3,  2'd3, 1'b1, 16'h0058},
        {4'd1, 5'd2,  2'd0, 1'b0, 16'h0058},
        {4'd3, 5'd3,  2'd3, 1'b0, 16'h0048},
        {4'd4, 5'd31, 2'd2, 1'b1, 16'h0048},
        {4'd0, 5'd1,  2'd0, 1'b0, 16'h0048},
        {4'd4, 5'd31, 2'd2, 1'b0, 16'h0040},
        {4'd5, 5'd6,  2'd1, 1'b1, 16'h0060},
        {4'd2, 5'd0,  2'd0, 1'b0, 16'h0020},
        {4'd5, 5'd6,  2'd1, 1'b0, 16'h0000}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: ctrl_irq_o=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive an event on a falling edge; return after the first rising edge.
    task automatic ev_start(input int dev, input int slot, input int pin, input logic lvl);
        @(negedge clk);
        ev_valid = 1'b1; ev_dev = 4'(dev); ev_slot = 5'(slot);
        ev_pin = 2'(pin); ev_level = lvl;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic wr_start(input int sel, input int val);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = 2'(sel); cfg_wr_data = 8'(val);
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // Full operations: the result is due after the second rising edge.
    task automatic ev(input int dev, input int slot, input int pin, input logic lvl);
        ev_start(dev, slot, pin, lvl);
        @(negedge clk);
    endtask

    task automatic wr(input int sel, input int val);
        wr_start(sel, val);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset output", ctrl_irq_o, 16'h0000);

        // R1/R5: the steering registers reset to 0x80, so nothing is routed.
        ev(0, 1, 0, 1'b1);
        check("R1 default steering disabled", ctrl_irq_o, 16'h0000);
        wr(0, 16);
        check("R5 value 16 unconnected", ctrl_irq_o, 16'h0000);
        wr(0, 15);
        check("R4 line0 to input15", ctrl_irq_o, 16'h8000);

        // R8: a write shows up only after the second edge.
        wr_start(0, 3);
        check("R8 write not visible after one edge", ctrl_irq_o, 16'h8000);
        @(negedge clk);
        check("R8 write visible after two edges", ctrl_irq_o, 16'h0008);
        ev(0, 1, 0, 1'b0);
        check("R9 device clear", ctrl_irq_o, 16'h0000);

        wr(1, 4); wr(2, 5); wr(3, 6);
        // R2/R3/R9 vector walk.
        for (int i = 0; i < NVEC; i++) begin
            ev(int'(VEC[i][27:24]), int'(VEC[i][23:19]), int'(VEC[i][18:17]), VEC[i][16]);
            check($sformatf("R2 R3 R9 vector %0d", i), ctrl_irq_o, VEC[i][15:0]);
        end

        // R6: two lines steered onto the same input.
        wr(1, 3);
        ev(0, 1, 0, 1'b1);
        ev(1, 2, 0, 1'b1);
        check("R6 shared input both high", ctrl_irq_o, 16'h0008);
        ev(0, 1, 0, 1'b0);
        check("R6 shared input held by other line", ctrl_irq_o, 16'h0008);

        // R7: a rewrite moves the level from the old input to the new one in one step.
        wr_start(1, 9);
        check("R7 before rewrite lands", ctrl_irq_o, 16'h0008);
        @(negedge clk);
        check("R7 old input drops, new rises", ctrl_irq_o, 16'h0200);

        // R8: an event shows up only after the second edge.
        ev_start(1, 2, 0, 1'b0);
        check("R8 event not visible after one edge", ctrl_irq_o, 16'h0200);
        @(negedge clk);
        check("R8 event visible after two edges", ctrl_irq_o, 16'h0000);

        // R1: a mid-run reset clears the levels and the steering.
        ev(2, 0, 0, 1'b1);
        wr(3, 7);
        check("R1 pre-reset routed", ctrl_irq_o, 16'h0080);
        do_reset();
        check("R1 output cleared by reset", ctrl_irq_o, 16'h0000);
        ev(6, 3, 2, 1'b1);
        check("R1 steering back to disabled", ctrl_irq_o, 16'h0000);
        wr(0, 2);
        check("R1 levels kept after reset, line0 to input2", ctrl_irq_o, 16'h0004);
        wr(0, 8'hFF);
        check("R5 value 0xFF unconnected", ctrl_irq_o, 16'h0000);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: ctrl_irq_o=%h expected=finish", ctrl_irq_o);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule